// File: doc/BRIEF.md
# Recency-Position Utility Monitor

This block watches the access stream of one core into a shared, 16-way set-associative cache. For every possible number of ways that core could be given, it estimates how many hits the core would get. It holds no data. A tag-only directory models true LRU replacement for this core's accesses alone. The directory covers only a sampled group of 32 cache sets, the sets whose index is a multiple of 32.

Every directory hit increments one counter, the one for the recency position where the tag was found. Position 0 is the most recently used line. Because LRU is a stack algorithm, the hits the core would get with n ways equal the sum of counters 0 to n-1. The block computes that sum for a requested n as a registered readout. An allocation engine outside the block reads the counters and the sum once per repartition epoch. It then issues a halve pulse, so that older history decays, or a clear pulse. There is one instance per core.

Top module: `umon_top`

## Requirements
- R1: An access is modelled only when the low 5 bits of its 10-bit set index are zero. The upper 5 bits then select one of 32 sampled sets. An access to any other set changes neither the counters nor any directory state.
- R2: Each sampled set holds up to 16 tags ordered by recency, and all sets start empty after reset. The first access to a tag in a set is a miss and leaves every counter unchanged.
- R3: On a hit at recency position p (0 = MRU, 15 = LRU), counter p increments by one. The tag then moves to position 0, and the entries at positions 0 to p-1 each move one position toward LRU.
- R4: On a miss, the tag is inserted at position 0, every entry moves one position toward LRU, and the entry at position 15 is dropped. After 16 other distinct tags, a re-access to the same tag is a miss.
- R5: The 16 counters are shared by all sampled sets. Hits in different sets at the same position add to the same counter.
- R6: Each counter is 16 bits wide and saturates at 65535.
- R7: A halve pulse shifts every counter right by one bit. A hit in the same cycle is counted after the shift.
- R8: A clear pulse sets all counters to zero. It takes precedence over halve and over a hit in the same cycle.
- R9: The cumulative readout equals the sum of counters 0 to n-1, where n is the requested way count. It appears one cycle after the request and reflects the counters as they stood before that clock edge. A request of 0 returns 0, and any request above 16 is treated as 16.
- R10: After reset all counters and the cumulative readout are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access request present this cycle |
| acc_set | input | 10 | Set index of the access |
| acc_tag | input | 20 | Tag of the access |
| halve | input | 1 | Decay pulse: halve all counters |
| clear | input | 1 | Zero all counters |
| query_ways | input | 5 | Way count n for the cumulative readout |
| hits_flat | output | 256 | Counter p at bits [16p+15:16p] |
| cum_hits | output | 20 | Registered sum of counters 0 to n-1 |

## Verification
The assertions assume the control inputs are known after reset. They also assume that a clear, or any sampled access, may arrive in any cycle, including together with halve. Under these assumptions the sum of all counters can grow by at most one per cycle when there is no clear or halve.

The stimulus draws set indices that are half sampled and half not, so the ignore rule is exercised as often as the lookup path. Tags come from a small pool so that hits land at many recency positions, as well as beyond the depth of 16. Halve and clear pulses arrive rarely and at random, including in cycles that also carry an access.

// File: rtl/umon_pkg.sv
package umon_pkg;
    localparam int UMON_WAYS  = 16;
    localparam int UMON_CNT_W = 16;
    localparam int UMON_POS_W = $clog2(UMON_WAYS);

    typedef logic [UMON_CNT_W-1:0] cnt_t;

    // Result of one directory lookup
    typedef struct packed {
        logic                  hit;
        logic [UMON_POS_W-1:0] pos;
    } probe_t;

    function automatic cnt_t sat_inc(cnt_t v);
        return (&v) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/umon_sampler.sv
module umon_sampler #(
    parameter int SET_W      = 10,
    parameter int SAMPLE_LOG = 5
) (
    input  logic                  acc_valid,
    input  logic [SET_W-1:0]      acc_set,
    output logic                  take,
    output logic [SAMPLE_LOG-1:0] slot
);
    localparam int LOW_W = SET_W - SAMPLE_LOG;

    assign take = acc_valid && (acc_set[LOW_W-1:0] == '0);
    assign slot = acc_set[SET_W-1 -: SAMPLE_LOG];
endmodule

// File: rtl/umon_lru_dir.sv
module umon_lru_dir
    import umon_pkg::*;
#(
    parameter int TAG_W      = 20,
    parameter int SAMPLE_LOG = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  take,
    input  logic [SAMPLE_LOG-1:0] slot,
    input  logic [TAG_W-1:0]      tag,
    output probe_t                probe
);
    localparam int SLOTS = 1 << SAMPLE_LOG;
    localparam int WAYS  = UMON_WAYS;
    localparam int POS_W = UMON_POS_W;

    // Position 0 holds the MRU entry of each sampled set
    logic [TAG_W-1:0] tag_q [SLOTS][WAYS];
    logic [WAYS-1:0]  vld_q [SLOTS];
    logic [POS_W-1:0] lim;

    always_comb begin
        probe = '0;
        for (int p = 0; p < WAYS; p++) begin
            if (vld_q[slot][p] && tag_q[slot][p] == tag) begin
                probe.hit = 1'b1;
                probe.pos = POS_W'(p);
            end
        end
        lim = probe.hit ? probe.pos : POS_W'(WAYS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++) vld_q[s] <= '0;
        end else if (take) begin
            tag_q[slot][0] <= tag;
            vld_q[slot][0] <= 1'b1;
            for (int p = 1; p < WAYS; p++) begin
                if (POS_W'(p) <= lim) begin
                    tag_q[slot][p] <= tag_q[slot][p-1];
                    vld_q[slot][p] <= vld_q[slot][p-1];
                end
            end
        end
    end
endmodule

// File: rtl/umon_hit_cnt.sv
module umon_hit_cnt
    import umon_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  probe_t                        ev,
    input  logic                          halve,
    input  logic                          clear,
    output logic [UMON_WAYS*UMON_CNT_W-1:0] cnt_flat
);
    localparam int WAYS  = UMON_WAYS;
    localparam int POS_W = UMON_POS_W;

    cnt_t cnt_q [WAYS];
    cnt_t cnt_d [WAYS];

    always_comb begin
        for (int p = 0; p < WAYS; p++) begin
            cnt_d[p] = halve ? (cnt_q[p] >> 1) : cnt_q[p];
            if (ev.hit && ev.pos == POS_W'(p)) cnt_d[p] = sat_inc(cnt_d[p]);
            if (clear) cnt_d[p] = '0;
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < WAYS; p++) begin
            if (rst) cnt_q[p] <= '0;
            else     cnt_q[p] <= cnt_d[p];
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_flat
        assign cnt_flat[g*UMON_CNT_W +: UMON_CNT_W] = cnt_q[g];
    end
endmodule

// File: rtl/umon_prefix.sv
module umon_prefix
    import umon_pkg::*;
#(
    parameter int QW    = $clog2(UMON_WAYS + 1),
    parameter int SUM_W = UMON_CNT_W + UMON_POS_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [UMON_WAYS*UMON_CNT_W-1:0] cnt_flat,
    input  logic [QW-1:0]                   n,
    output logic [SUM_W-1:0]                cum
);
    localparam int WAYS = UMON_WAYS;

    logic [QW-1:0]    n_eff;
    logic [SUM_W-1:0] acc;

    always_comb begin
        n_eff = (n > QW'(WAYS)) ? QW'(WAYS) : n;
        acc   = '0;
        for (int p = 0; p < WAYS; p++) begin
            if (QW'(p) < n_eff) acc = acc + SUM_W'(cnt_flat[p*UMON_CNT_W +: UMON_CNT_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cum <= '0;
        else     cum <= acc;
    end
endmodule

// File: rtl/umon_top.sv
module umon_top
    import umon_pkg::*;
#(
    parameter int SET_W      = 10,
    parameter int TAG_W      = 20,
    parameter int SAMPLE_LOG = 5,
    parameter int QW         = $clog2(UMON_WAYS + 1),
    parameter int SUM_W      = UMON_CNT_W + UMON_POS_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            acc_valid,
    input  logic [SET_W-1:0]                acc_set,
    input  logic [TAG_W-1:0]                acc_tag,
    input  logic                            halve,
    input  logic                            clear,
    input  logic [QW-1:0]                   query_ways,
    output logic [UMON_WAYS*UMON_CNT_W-1:0] hits_flat,
    output logic [SUM_W-1:0]                cum_hits
);
    logic                  take;
    logic [SAMPLE_LOG-1:0] slot;
    probe_t                probe;
    probe_t                ev;

    umon_sampler #(.SET_W(SET_W), .SAMPLE_LOG(SAMPLE_LOG)) u_samp (
        .acc_valid(acc_valid), .acc_set(acc_set), .take(take), .slot(slot)
    );

    umon_lru_dir #(.TAG_W(TAG_W), .SAMPLE_LOG(SAMPLE_LOG)) u_dir (
        .clk(clk), .rst(rst), .take(take), .slot(slot), .tag(acc_tag), .probe(probe)
    );

    assign ev.hit = take && probe.hit;
    assign ev.pos = probe.pos;

    umon_hit_cnt u_cnt (
        .clk(clk), .rst(rst), .ev(ev), .halve(halve), .clear(clear), .cnt_flat(hits_flat)
    );

    umon_prefix #(.QW(QW), .SUM_W(SUM_W)) u_pfx (
        .clk(clk), .rst(rst), .cnt_flat(hits_flat), .n(query_ways), .cum(cum_hits)
    );
endmodule

// File: rtl/umon_chk.sv
module umon_chk
    import umon_pkg::*;
#(
    parameter int SET_W      = 10,
    parameter int SAMPLE_LOG = 5,
    parameter int QW         = 5,
    parameter int SUM_W      = 20
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            acc_valid,
    input logic [SET_W-1:0]                acc_set,
    input logic                            halve,
    input logic                            clear,
    input logic [QW-1:0]                   query_ways,
    input logic [UMON_WAYS*UMON_CNT_W-1:0] hits_flat,
    input logic [SUM_W-1:0]                cum_hits
);
    localparam int LOW_W = SET_W - SAMPLE_LOG;
    localparam int TOT_W = UMON_CNT_W + UMON_POS_W + 1;

    logic [TOT_W-1:0] total;
    always_comb begin
        total = '0;
        for (int p = 0; p < UMON_WAYS; p++)
            total = total + TOT_W'(hits_flat[p*UMON_CNT_W +: UMON_CNT_W]);
    end

    assert_ignore_unsampled_R1: assert property (@(posedge clk) disable iff (rst)
        (!halve && !clear && !(acc_valid && acc_set[LOW_W-1:0] == '0)) |=> $stable(hits_flat));

    assert_one_hit_per_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (!halve && !clear) |=> (total == $past(total) || total == $past(total) + 1'b1));

    assert_halve_shift_R7: assert property (@(posedge clk) disable iff (rst)
        (halve && !clear && !acc_valid) |=>
        hits_flat[UMON_CNT_W-1:0] == ($past(hits_flat[UMON_CNT_W-1:0]) >> 1));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (hits_flat == '0));

    assert_zero_query_R9: assert property (@(posedge clk) disable iff (rst)
        (query_ways == '0) |=> (cum_hits == '0));
endmodule

bind umon_top umon_chk #(.SET_W(SET_W), .SAMPLE_LOG(SAMPLE_LOG), .QW(QW), .SUM_W(SUM_W)) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set), .halve(halve),
    .clear(clear), .query_ways(query_ways), .hits_flat(hits_flat), .cum_hits(cum_hits)
);

// File: tb/tb_umon_top.sv
module tb_umon_top;
    localparam int WAYS = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         acc_valid;
    logic [9:0]   acc_set;
    logic [19:0]  acc_tag;
    logic         halve;
    logic         clear;
    logic [4:0]   query_ways;
    logic [255:0] hits_flat;
    logic [19:0]  cum_hits;

    int n_chk  = 0;
    int n_fail = 0;

    int unsigned m_tag [32][WAYS];
    bit          m_vld [32][WAYS];
    int          m_cnt [WAYS];

    umon_top dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set), .acc_tag(acc_tag),
        .halve(halve), .clear(clear), .query_ways(query_ways),
        .hits_flat(hits_flat), .cum_hits(cum_hits)
    );

    always #4 clk = ~clk;

    function automatic int model_cum(int q);
        int s = 0;
        int n = (q > WAYS) ? WAYS : q;
        for (int p = 0; p < n; p++) s += m_cnt[p];
        return s;
    endfunction

    function automatic void model_step(bit v, int s, int unsigned t, bit hv, bit cl);
        int h = -1;
        int slot;
        int lim;
        for (int p = 0; p < WAYS; p++) if (hv) m_cnt[p] = m_cnt[p] >> 1;
        if (v && (s % 32) == 0) begin
            slot = s / 32;
            for (int p = 0; p < WAYS; p++) if (m_vld[slot][p] && m_tag[slot][p] == t) h = p;
            if (h >= 0 && m_cnt[h] < 65535) m_cnt[h]++;
            lim = (h >= 0) ? h : WAYS - 1;
            for (int p = lim; p >= 1; p--) begin
                m_tag[slot][p] = m_tag[slot][p-1];
                m_vld[slot][p] = m_vld[slot][p-1];
            end
            m_tag[slot][0] = t;
            m_vld[slot][0] = 1'b1;
        end
        if (cl) for (int p = 0; p < WAYS; p++) m_cnt[p] = 0;
    endfunction

    task automatic check_all(string req, int exp_cum);
        n_chk++;
        for (int p = 0; p < WAYS; p++) begin
            if (int'(hits_flat[p*16 +: 16]) != m_cnt[p]) begin
                n_fail++;
                $display("FAIL %s counter %0d: actual %0d expected %0d",
                         req, p, hits_flat[p*16 +: 16], m_cnt[p]);
                break;
            end
        end
        n_chk++;
        if (int'(cum_hits) != exp_cum) begin
            n_fail++;
            $display("FAIL R9 (%s) cumulative: actual %0d expected %0d", req, cum_hits, exp_cum);
        end
    endtask

    task automatic step(bit v, int s, int unsigned t, bit hv, bit cl, int q, string req);
        int ec;
        acc_valid  = v;
        acc_set    = 10'(s);
        acc_tag    = 20'(t);
        halve      = hv;
        clear      = cl;
        query_ways = 5'(q);
        ec = model_cum(q);
        @(negedge clk);
        model_step(v, s, t, hv, cl);
        check_all(req, ec);
    endtask

    task automatic expect_cnt(string req, int p, int e);
        n_chk++;
        if (int'(hits_flat[p*16 +: 16]) != e) begin
            n_fail++;
            $display("FAIL %s direct counter %0d: actual %0d expected %0d",
                     req, p, hits_flat[p*16 +: 16], e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        for (int s = 0; s < 32; s++) for (int p = 0; p < WAYS; p++) m_vld[s][p] = 0;
        for (int p = 0; p < WAYS; p++) m_cnt[p] = 0;
        rst = 1'b1; acc_valid = 0; acc_set = 0; acc_tag = 0; halve = 0; clear = 0; query_ways = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        step(0, 0, 0, 0, 0, 16, "R10");
        // R2 first touch misses, R3 repeat hits at MRU
        step(1, 0, 5, 0, 0, 0, "R2");
        expect_cnt("R2", 0, 0);
        step(1, 0, 5, 0, 0, 0, "R3");
        expect_cnt("R3", 0, 1);
        // R3: hit at position 3
        for (int t = 1; t <= 4; t++) step(1, 32, t, 0, 0, 1, "R3");
        step(1, 32, 1, 0, 0, 4, "R3");
        expect_cnt("R3", 3, 1);
        step(1, 32, 4, 0, 0, 4, "R3");
        expect_cnt("R3", 1, 1);
        // R4: 17 distinct tags evict the first
        for (int t = 100; t <= 116; t++) step(1, 64, t, 0, 0, 2, "R4");
        step(1, 64, 100, 0, 0, 16, "R4");
        expect_cnt("R4", 15, 0);
        step(1, 64, 102, 0, 0, 16, "R4");
        expect_cnt("R4", 15, 1);
        // R1: unsampled sets ignored, sampled state untouched
        step(1, 1, 5, 0, 0, 16, "R1");
        step(1, 1, 5, 0, 0, 16, "R1");
        step(1, 31, 77, 0, 0, 16, "R1");
        step(1, 0, 5, 0, 0, 16, "R1");
        expect_cnt("R1", 0, 2);
        // R5: different sets share counters
        step(1, 96, 9, 0, 0, 3, "R5");
        step(1, 96, 9, 0, 0, 3, "R5");
        step(1, 128, 9, 0, 0, 3, "R5");
        step(1, 128, 9, 0, 0, 3, "R5");
        expect_cnt("R5", 0, 4);
        // R9: several way counts, including 0 and above 16
        for (int q = 0; q <= 20; q += 5) step(0, 0, 0, 0, 0, q, "R9");
        // R7: halve together with a hit
        step(1, 128, 9, 1, 0, 16, "R7");
        expect_cnt("R7", 0, 3);
        // R8: clear beats halve and hit
        step(1, 128, 9, 1, 1, 16, "R8");
        expect_cnt("R8", 0, 0);
        // R6: saturation
        for (int i = 0; i < 65540; i++) step(1, 128, 9, 0, 0, 1, "R6");
        expect_cnt("R6", 0, 65535);
        step(0, 0, 0, 1, 0, 1, "R7");
        expect_cnt("R7", 0, 32767);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int s;
            int unsigned t = $urandom_range(0, 21);
            if ($urandom_range(0, 1) == 0) s = 32 * $urandom_range(0, 3);
            else s = $urandom_range(0, 1023);
            step($urandom_range(0, 9) != 0, s, t,
                 $urandom_range(0, 199) == 0, $urandom_range(0, 999) == 0,
                 $urandom_range(0, 20), "R3/R4/R1 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule